// File: doc/BRIEF.md
# OFDM Grid Stream Framer

The framer carries two demodulated resource grids, one after the other, over a single AXI4-Stream link that feeds a DMA engine. A start pulse arms one transfer sequence. The first grid is the synchronization-block grid. It has a fixed size of 240 subcarriers by 4 OFDM symbols, which is 960 samples, and it goes out as a packet of its own. The data-channel grid follows. Its size is the configured subcarrier count N multiplied by the number of OFDM symbols in two slots, where one slot is 14 symbols. How the data grid is split into packets depends on the spacing mode. In the narrow (15 kHz) mode each slot is a separate packet. In the wide (30 kHz) mode both slots travel in one packet.

The block counts accepted samples and places TLAST at every packet boundary. It applies output backpressure to the upstream valid/ready handshake, so no sample is dropped or repeated. A two-bit status output shows whether the block is idle, moving the synchronization grid or moving the data grid. The subcarrier count and the spacing mode are captured at the start pulse and held until the sequence ends.

Top module: `fgs_grid_framer`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `m_valid_o` is 0, `status_o` is 0 (idle) and `s_ready_o` is 0.
- R2: A start pulse has an effect only while the block is idle. One cycle after it, `status_o` reads 1. `cfg_nsc_i` and `cfg_wide_i` are sampled in that same cycle and their later changes are ignored. A start pulse that arrives during a sequence is ignored, and this includes a pulse in the cycle that accepts the final data sample.
- R3: Samples 1 to 960 of a sequence form the synchronization-grid packet. TLAST is 1 on sample 960 and 0 on samples 1 to 959.
- R4: When `cfg_wide_i`=0 (15 kHz mode) was captured, the data grid is sent as two packets of 14·N samples each, with TLAST on the last sample of each packet only.
- R5: When `cfg_wide_i`=1 (30 kHz mode) was captured, the data grid is sent as one packet of 28·N samples, with TLAST on its last sample only.
- R6: The output carries exactly the accepted input samples, in order, with no loss and no duplication. A sequence accepts 960 + 28·N samples.
- R7: While `m_valid_o`=1 and `m_ready_i`=0, the values of `m_valid_o`, `m_data_o` and `m_last_o` are held in the next cycle.
- R8: `status_o` encodes 0 = idle, 1 = synchronization grid, 2 = data grid. Input samples 1 to 960 are accepted with status 1 and later samples with status 2. Status returns to 0 in the cycle after the final sample is accepted.
- R9: While idle, `s_ready_o` is 0, input samples are not taken and no output beat is produced.
- R10: With `m_ready_i` held at 1 and input always valid, one sample is accepted every cycle across the whole sequence, packet boundaries included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Starts a sequence when the block is idle |
| cfg_nsc_i | input | 10 | Data-grid subcarrier count N, from 1 to 576 |
| cfg_wide_i | input | 1 | Spacing mode: 0 = 15 kHz (one slot per packet), 1 = 30 kHz (both slots in one packet) |
| s_valid_i | input | 1 | Input sample valid |
| s_data_i | input | 32 | Input grid sample |
| s_ready_o | output | 1 | Input sample accepted when high together with valid |
| m_valid_o | output | 1 | Stream TVALID |
| m_data_o | output | 32 | Stream TDATA |
| m_last_o | output | 1 | Stream TLAST, the last sample of a packet |
| m_ready_i | input | 1 | Stream TREADY |
| status_o | output | 2 | 0 idle, 1 synchronization grid, 2 data grid |

## Verification
The start pulse and the final data-sample handshake can fall in the same cycle. The bench provokes this by holding start high while the last sample of a sequence is offered, so both land on one edge. It judges the outcome by status falling to idle and staying idle, with no further beats. The second coincidence is a packet boundary inside a stall: TLAST must sit on the correct sample while `m_ready_i` toggles from a pseudo-random pattern. This is judged against last-sample positions computed from N and the mode, and against a held-output check on every stalled cycle.

// File: rtl/fgs_pkg.sv
package fgs_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_SYNC = 2'd1,
    PH_DATA = 2'd2
  } fgs_phase_e;
endpackage

// File: rtl/fgs_seq.sv
module fgs_seq
  import fgs_pkg::*;
#(
  parameter int NSC_MAX  = 576,
  parameter int NSC_W    = 10,
  parameter int CNT_W    = 14,
  parameter int SYNC_LEN = 960,
  parameter int SYM_SLOT = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [NSC_W-1:0] cfg_nsc_i,
  input  logic             cfg_dual_i,
  input  logic             acc_i,
  output fgs_phase_e       phase_o,
  output logic             last_o
);
  fgs_phase_e       phase_q;
  logic [NSC_W-1:0] nsc_q;
  logic             dual_q;
  logic             seg_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] slot_len;
  logic [CNT_W-1:0] pkt_len;

  // packet length for the current phase and segment
  always_comb begin
    slot_len = CNT_W'(nsc_q) * CNT_W'(SYM_SLOT);
    if (phase_q == PH_SYNC)
      pkt_len = CNT_W'(SYNC_LEN);
    else if (dual_q)
      pkt_len = slot_len << 1;
    else
      pkt_len = slot_len;
  end

  assign last_o  = (cnt_q == pkt_len - CNT_W'(1));
  assign phase_o = phase_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      nsc_q   <= '0;
      dual_q  <= 1'b0;
      seg_q   <= 1'b0;
      cnt_q   <= '0;
    end else begin
      case (phase_q)
        PH_IDLE: begin
          if (start_i) begin
            phase_q <= PH_SYNC;
            nsc_q   <= cfg_nsc_i;
            dual_q  <= cfg_dual_i;
            seg_q   <= 1'b0;
            cnt_q   <= '0;
          end
        end
        default: begin
          if (acc_i) begin
            if (last_o) begin
              cnt_q <= '0;
              if (phase_q == PH_SYNC)
                phase_q <= PH_DATA;
              else if (!dual_q && !seg_q)
                seg_q <= 1'b1;
              else
                phase_q <= PH_IDLE;
            end else begin
              cnt_q <= cnt_q + CNT_W'(1);
            end
          end
        end
      endcase
    end
  end

  AST_START_CFG_RANGE: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_IDLE && start_i) |-> (cfg_nsc_i != '0 && cfg_nsc_i <= NSC_W'(NSC_MAX))); // R2
  AST_SYNC_ONLY_FROM_START: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_SYNC && $past(phase_q) == PH_IDLE) |-> $past(start_i)); // R2
  AST_CFG_HELD: assert property (@(posedge clk) disable iff (rst)
    (phase_q != PH_IDLE && $past(phase_q) != PH_IDLE) |-> ($stable(nsc_q) && $stable(dual_q))); // R2
  AST_SYNC_END_ON_LAST: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_DATA && $past(phase_q) == PH_SYNC) |-> $past(acc_i && last_o)); // R3
  AST_CNT_IN_PACKET: assert property (@(posedge clk) disable iff (rst)
    (phase_q != PH_IDLE) |-> (cnt_q < pkt_len)); // R5
endmodule

// File: rtl/fgs_out_reg.sv
module fgs_out_reg #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              last_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic              last_o,
  output logic              space_o
);
  assign space_o = !valid_o || ready_i;

  always_ff @(posedge clk) begin
    if (rst)
      valid_o <= 1'b0;
    else if (load_i)
      valid_o <= 1'b1;
    else if (ready_i)
      valid_o <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (load_i) begin
      data_o <= data_i;
      last_o <= last_i;
    end
  end

  AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (rst)
    (valid_o && !ready_i) |=> (valid_o && $stable(data_o) && $stable(last_o))); // R7
endmodule

// File: rtl/fgs_grid_framer.sv
module fgs_grid_framer
  import fgs_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NSC_MAX  = 576,
  parameter int SYNC_SC  = 240,
  parameter int SYNC_SYM = 4,
  parameter int SYM_SLOT = 14,
  localparam int NSC_W    = $clog2(NSC_MAX + 1),
  localparam int SYNC_LEN = SYNC_SC * SYNC_SYM,
  localparam int MAX_PKT  = 2 * SYM_SLOT * NSC_MAX,
  localparam int CNT_W    = $clog2((MAX_PKT > SYNC_LEN ? MAX_PKT : SYNC_LEN) + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [NSC_W-1:0]  cfg_nsc_i,
  input  logic              cfg_wide_i,
  input  logic              s_valid_i,
  input  logic [DATA_W-1:0] s_data_i,
  output logic              s_ready_o,
  output logic              m_valid_o,
  output logic [DATA_W-1:0] m_data_o,
  output logic              m_last_o,
  input  logic              m_ready_i,
  output logic [1:0]        status_o
);
  fgs_phase_e phase;
  logic       pkt_last;
  logic       space;
  logic       in_fire;

  assign s_ready_o = (phase != PH_IDLE) && space;
  assign in_fire   = s_valid_i && s_ready_o;
  assign status_o  = phase;

  fgs_seq #(
    .NSC_MAX (NSC_MAX),
    .NSC_W   (NSC_W),
    .CNT_W   (CNT_W),
    .SYNC_LEN(SYNC_LEN),
    .SYM_SLOT(SYM_SLOT)
  ) seq_i (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start_i),
    .cfg_nsc_i (cfg_nsc_i),
    .cfg_dual_i(cfg_wide_i),
    .acc_i     (in_fire),
    .phase_o   (phase),
    .last_o    (pkt_last)
  );

  fgs_out_reg #(
    .DATA_W(DATA_W)
  ) oreg_i (
    .clk    (clk),
    .rst    (rst),
    .load_i (in_fire),
    .data_i (s_data_i),
    .last_i (pkt_last),
    .ready_i(m_ready_i),
    .valid_o(m_valid_o),
    .data_o (m_data_o),
    .last_o (m_last_o),
    .space_o(space)
  );

  AST_IDLE_NO_EMIT: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_IDLE && !m_valid_o) |=> !m_valid_o); // R9
  AST_STATUS_CODE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(status_o)); // R8
endmodule

// File: tb/fgs_grid_framer_tb_top.sv
module fgs_grid_framer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SYNC_N = 960;
  localparam int NVEC = 7;
  // {wide, nsc}
  localparam logic [10:0] VEC [NVEC] = '{
    {1'b0, 10'd1}, {1'b1, 10'd1}, {1'b0, 10'd7}, {1'b1, 10'd7},
    {1'b0, 10'd576}, {1'b1, 10'd576}, {1'b1, 10'd240}
  };

  logic        clk = 1'b0;
  logic        rst;
  logic        start;
  logic [9:0]  cfg_nsc;
  logic        cfg_wide;
  logic        s_valid;
  logic [31:0] s_data;
  logic        s_ready;
  logic        m_valid;
  logic [31:0] m_data;
  logic        m_last;
  logic        m_ready;
  logic [1:0]  status;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc++;

  fgs_grid_framer dut_i (
    .clk(clk), .rst(rst), .start_i(start), .cfg_nsc_i(cfg_nsc), .cfg_wide_i(cfg_wide),
    .s_valid_i(s_valid), .s_data_i(s_data), .s_ready_o(s_ready),
    .m_valid_o(m_valid), .m_data_o(m_data), .m_last_o(m_last), .m_ready_i(m_ready),
    .status_o(status)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit exp_last(input int j, input bit wide, input int n);
    return (j == SYNC_N - 1) || (j == SYNC_N + 28*n - 1) ||
           (!wide && j == SYNC_N + 14*n - 1);
  endfunction

  task automatic run_seq(input int id, input bit wide, input int n,
                         input bit stall, input int start_at_in);
    int total, in_idx, out_idx, first_c, last_c, guard, start_at;
    int bad_d, bad_ls, bad_ld, bad_st, bad_h;
    longint ad, ed, als, els, ald, eld, ast, est;
    logic [31:0] prev_d;
    logic prev_l, prev_stall;
    string lreq;
    total = SYNC_N + 28*n;
    start_at = (start_at_in < 0) ? total - 1 : start_at_in;
    bad_d = 0; bad_ls = 0; bad_ld = 0; bad_st = 0; bad_h = 0;
    ad = 0; ed = 0; als = 0; els = 0; ald = 0; eld = 0; ast = 0; est = 0;
    first_c = 0; last_c = 0;
    @(negedge clk);
    cfg_nsc = 10'(n); cfg_wide = wide; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cfg_nsc = (n == 1) ? 10'd2 : 10'd1; cfg_wide = ~wide;
    #1;
    check(status == 2'd1, "R2", "status after start", status, 1);
    prev_stall = 1'b0; prev_d = '0; prev_l = 1'b0;
    in_idx = 0; out_idx = 0; guard = 0;
    while (out_idx < total && guard < 60000) begin
      guard++;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      m_ready = stall ? (lfsr[0] | lfsr[3]) : 1'b1;
      s_valid = (in_idx < total) && (stall ? (lfsr[5] | lfsr[7]) : 1'b1);
      s_data  = {id[7:0], in_idx[23:0]};
      start   = (in_idx == start_at);
      #1;
      if (prev_stall && (!m_valid || m_data !== prev_d || m_last !== prev_l)) bad_h++;
      if (m_valid && m_ready) begin
        if (m_data !== {id[7:0], out_idx[23:0]}) begin
          if (bad_d == 0) begin ad = m_data; ed = {id[7:0], out_idx[23:0]}; end
          bad_d++;
        end
        if (m_last !== exp_last(out_idx, wide, n)) begin
          if (out_idx < SYNC_N) begin
            if (bad_ls == 0) begin als = out_idx; els = m_last; end
            bad_ls++;
          end else begin
            if (bad_ld == 0) begin ald = out_idx; eld = m_last; end
            bad_ld++;
          end
        end
        out_idx++;
      end
      if (s_valid && s_ready) begin
        if (status !== ((in_idx < SYNC_N) ? 2'd1 : 2'd2)) begin
          if (bad_st == 0) begin ast = status; est = (in_idx < SYNC_N) ? 1 : 2; end
          bad_st++;
        end
        if (in_idx == 0) first_c = cyc;
        last_c = cyc;
        in_idx++;
      end
      prev_stall = m_valid && !m_ready;
      prev_d = m_data; prev_l = m_last;
      @(negedge clk);
    end
    s_valid = 1'b0; start = 1'b0; m_ready = 1'b1;
    #1;
    lreq = wide ? "R5" : "R4";
    check(out_idx == total, "R6", "output beat count", out_idx, total);
    check(in_idx == total, "R6", "accepted sample count", in_idx, total);
    check(bad_d == 0, "R6", "first mismatched data", ad, ed);
    check(bad_ls == 0, "R3", "sync TLAST wrong at index (actual=index)", als, els);
    check(bad_ld == 0, lreq, "data TLAST wrong at index (actual=index)", ald, eld);
    check(bad_st == 0, "R8", "status at accept", ast, est);
    check(status == 2'd0, "R8", "status after final sample", status, 0);
    if (stall) check(bad_h == 0, "R7", "stalled output changed count", bad_h, 0);
    else check(last_c - first_c == total - 1, "R10", "accept span cycles",
               last_c - first_c, total - 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int bad;
    rst = 1'b1; start = 1'b0; cfg_nsc = 10'd1; cfg_wide = 1'b0;
    s_valid = 1'b0; s_data = '0; m_ready = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    check(m_valid == 1'b0 && status == 2'd0 && s_ready == 1'b0, "R1", "outputs in reset",
          {m_valid, status, s_ready}, 0);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check(m_valid == 1'b0 && status == 2'd0 && s_ready == 1'b0, "R1", "outputs after reset",
          {m_valid, status, s_ready}, 0);

    // idle: input offered, nothing taken
    bad = 0;
    s_valid = 1'b1; s_data = 32'hDEAD0000;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); #1;
      if (s_ready || m_valid || status != 2'd0) bad++;
    end
    s_valid = 1'b0;
    check(bad == 0, "R9", "idle cycles with activity", bad, 0);

    // table walk: even entries full rate, odd entries with stalls
    for (int v = 0; v < NVEC; v++)
      run_seq(v + 1, VEC[v][10], int'(VEC[v][9:0]), v[0], 500);

    // start in the same cycle as the final data-sample accept
    run_seq(20, 1'b1, 2, 1'b0, -1);
    bad = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); #1;
      if (status != 2'd0 || m_valid) bad++;
    end
    check(bad == 0, "R2", "cycles busy after colliding start", bad, 0);
    run_seq(21, 1'b0, 3, 1'b1, -1);
    run_seq(22, 1'b0, 2, 1'b0, 100);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule